// File: doc/BRIEF.md
# Windowed Watchdog Timer

This block is a watchdog with a time window. It is clocked by the peripheral bus clock. A fixed prescaler of `FIX_DIV` bus clocks (4096 by default) feeds a second divider that software selects. Together they step a 7-bit counter downward. Software refreshes the counter by writing a new value to it. The refresh must land inside a window. The top of the window is a programmable threshold. The bottom is the fixed value 0x40: the counter passing from 0x40 to 0x3F is the failure condition.

Once software has armed the block, two events raise a one-cycle reset request. The first is a refresh written while the counter is still above the threshold, which is too early. The second is the counter stepping below 0x40, which is too late. After a request every register returns to its reset value and the prescaler restarts. A block enable gates the whole block. With the enable low, nothing advances and writes are ignored.

Top module: `win_wdog`

## Requirements
- R1: After reset `cnt_val` is 0x7F and `rst_req` is 0. The threshold is 0x7F, the timebase code is 0, and the block is not armed.
- R2: While `blk_en` is 0 the counter and the prescaler hold their values. Both write strobes are ignored and `rst_req` stays 0. When `blk_en` returns to 1, counting resumes from the held prescaler phase.
- R3: The counter decreases by exactly one per step and wraps modulo 128. The timebase code is `cfg_tb`: 0 divides by 1, 1 by 2, 2 by 4 and 3 by 8. Each step comes `FIX_DIV` × 2^code enabled clocks after the previous step, or after the last prescaler clear.
- R4: Before the block is armed, the counter may step below 0x40 without any reset request. A counter write loads `ctl_data[6:0]` whatever the counter value.
- R5: When the block is armed and a step takes the counter from 0x40 to 0x3F, `rst_req` is raised.
- R6: When the block is armed, a counter write made while the counter is greater than the threshold raises `rst_req` instead of loading.
- R7: When the block is armed, a counter write made while the counter is between 0x40 and the threshold is accepted with no request. Both bounds are inclusive.
- R8: A counter write that loads a value below 0x40 raises `rst_req` if the block is armed or if the same write sets the arm bit `ctl_data[7]`.
- R9: `rst_req` is high for exactly one clock, in the cycle after the offending edge. In that cycle `cnt_val` is 0x7F, the block is disarmed, the configuration is back to its reset value and the prescaler has restarted.
- R10: The arm bit is sticky. A counter write with `ctl_data[7]` = 0 leaves an armed block armed. Only R9 clears it.
- R11: A counter write takes priority over a step on the same edge. A reset request takes priority over both.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| blk_en | input | 1 | Block clock enable; 0 freezes the block |
| ctl_wr | input | 1 | Counter write strobe |
| ctl_data | input | 8 | Bit 7 arms the block; bits 6:0 are the counter value to load |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_win | input | 7 | Upper window threshold |
| cfg_tb | input | 2 | Timebase code (extra divide by 2^code) |
| rst_req | output | 1 | One-cycle reset request |
| cnt_val | output | 7 | Current counter value |

## Verification
Every result is registered once. A write strobe sampled at one rising edge shows its load, or its reset request, on the outputs right after that same edge. A step shows on the edge where the prescaler completes its period. The bench counts enabled edges from the enable point and from every expected prescaler restart. From that count it lists each expected counter value and the running count of request pulses against an exact cycle number, and it compares them half a clock after that edge. A request two cycles wide, or one cycle off, shows up as a wrong pulse count at the next scheduled check.

// File: rtl/wwd_pkg.sv
package wwd_pkg;

    localparam int CNT_W = 7;
    localparam int TB_W  = 2;
    localparam int EXT_W = (1 << TB_W) - 1;

    localparam logic [CNT_W-1:0] CNT_TOP   = '1;
    localparam logic [CNT_W-1:0] CNT_FLOOR = CNT_W'(1) << (CNT_W - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             armed;
        logic [CNT_W-1:0] win;
        logic [TB_W-1:0]  tb;
        logic             req;
    } wd_state_t;

    localparam wd_state_t WD_RST = '{
        cnt:   CNT_TOP,
        armed: 1'b0,
        win:   CNT_TOP,
        tb:    '0,
        req:   1'b0
    };

endpackage

// File: rtl/wwd_prescale.sv
module wwd_prescale
    import wwd_pkg::*;
#(
    parameter int FIX_DIV = 4096
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en,
    input  logic            clr,
    input  logic [TB_W-1:0] tb,
    output logic            tick
);

    localparam int PRE_W = (FIX_DIV > 1) ? $clog2(FIX_DIV) : 1;

    logic             base_wrap;
    logic [EXT_W-1:0] ext_d, ext_q;
    logic [EXT_W-1:0] ext_lim;

    generate
        if (FIX_DIV == 1) begin : g_nofix
            assign base_wrap = en;
        end else begin : g_fix
            logic [PRE_W-1:0] pre_d, pre_q;

            always_comb begin
                pre_d = pre_q;
                if (clr) begin
                    pre_d = '0;
                end else if (en) begin
                    if (pre_q == PRE_W'(FIX_DIV - 1)) begin
                        pre_d = '0;
                    end else begin
                        pre_d = pre_q + PRE_W'(1);
                    end
                end
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    pre_q <= '0;
                end else begin
                    pre_q <= pre_d;
                end
            end

            assign base_wrap = en && (pre_q == PRE_W'(FIX_DIV - 1));
        end
    endgenerate

    always_comb begin
        ext_lim = EXT_W'((32'd1 << tb) - 32'd1);
        tick    = base_wrap && (ext_q >= ext_lim);
        ext_d   = ext_q;
        if (clr) begin
            ext_d = '0;
        end else if (tick) begin
            ext_d = '0;
        end else if (base_wrap) begin
            ext_d = ext_q + EXT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ext_q <= '0;
        end else begin
            ext_q <= ext_d;
        end
    end

endmodule

// File: rtl/wwd_judge.sv
module wwd_judge
    import wwd_pkg::*;
(
    input  logic             armed,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] win,
    input  logic             wr,
    input  logic             wr_arm,
    input  logic [CNT_W-1:0] wr_val,
    input  logic             tick,
    output logic             fault,
    output logic             load
);

    logic too_early;
    logic too_low_load;
    logic too_late;

    always_comb begin
        too_early    = wr && armed && (cnt > win);
        too_low_load = wr && (armed || wr_arm) && (wr_val < CNT_FLOOR);
        too_late     = !wr && tick && armed && (cnt == CNT_FLOOR);
        fault        = too_early || too_low_load || too_late;
        load         = wr && !fault;
    end

endmodule

// File: rtl/win_wdog.sv
module win_wdog
    import wwd_pkg::*;
#(
    parameter int FIX_DIV = 4096
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         blk_en,
    input  logic         ctl_wr,
    input  logic [7:0]   ctl_data,
    input  logic         cfg_wr,
    input  logic [6:0]   cfg_win,
    input  logic [1:0]   cfg_tb,
    output logic         rst_req,
    output logic [6:0]   cnt_val
);

    wd_state_t st_d, st_q;

    logic tick;
    logic fault;
    logic load;
    logic wr_ok;
    logic clr;
    logic cur_armed;
    logic [CNT_W-1:0] cur_win;

    assign wr_ok = blk_en && ctl_wr;
    assign clr   = blk_en && fault;

    wwd_prescale #(
        .FIX_DIV (FIX_DIV)
    ) i_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (blk_en),
        .clr   (clr),
        .tb    (st_q.tb),
        .tick  (tick)
    );

    wwd_judge i_judge (
        .armed  (st_q.armed),
        .cnt    (st_q.cnt),
        .win    (st_q.win),
        .wr     (wr_ok),
        .wr_arm (ctl_data[7]),
        .wr_val (ctl_data[CNT_W-1:0]),
        .tick   (tick),
        .fault  (fault),
        .load   (load)
    );

    always_comb begin
        st_d     = st_q;
        st_d.req = 1'b0;
        if (blk_en) begin
            if (fault) begin
                st_d     = WD_RST;
                st_d.req = 1'b1;
            end else begin
                if (cfg_wr) begin
                    st_d.win = cfg_win;
                    st_d.tb  = cfg_tb;
                end
                if (load) begin
                    st_d.cnt   = ctl_data[CNT_W-1:0];
                    st_d.armed = st_q.armed | ctl_data[7];
                end else if (tick) begin
                    st_d.cnt = st_q.cnt - CNT_W'(1);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= WD_RST;
        end else begin
            st_q <= st_d;
        end
    end

    assign rst_req   = st_q.req;
    assign cnt_val   = st_q.cnt;
    assign cur_armed = st_q.armed;
    assign cur_win   = st_q.win;

endmodule

// File: rtl/wwd_chk.sv
module wwd_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       blk_en,
    input logic       ctl_wr,
    input logic [7:0] ctl_data,
    input logic       rst_req,
    input logic [6:0] cnt_val,
    input logic       cur_armed,
    input logic [6:0] cur_win,
    input logic       tick
);

    p_pulse_one_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !rst_req)
        else $error("rst_req wider than one cycle");

    p_top_after_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> (cnt_val == 7'h7F && !cur_armed))
        else $error("state not restored with request");

    p_frozen_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !blk_en |=> ($stable(cnt_val) && !rst_req))
        else $error("block moved while disabled");

    p_single_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_en && !ctl_wr) |=>
            (rst_req || cnt_val == $past(cnt_val) || cnt_val == $past(cnt_val) - 7'd1))
        else $error("counter moved by more than one step");

    p_early_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_en && ctl_wr && cur_armed && cnt_val > cur_win) |=> rst_req)
        else $error("early refresh not caught");

    p_floor_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_en && !ctl_wr && cur_armed && tick && cnt_val == 7'h40) |=> rst_req)
        else $error("floor crossing not caught");

    p_quiet_unarmed_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!cur_armed && !(blk_en && ctl_wr && ctl_data[7])) |=> !rst_req)
        else $error("request while unarmed");

endmodule

bind win_wdog wwd_chk i_wwd_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .blk_en    (blk_en),
    .ctl_wr    (ctl_wr),
    .ctl_data  (ctl_data),
    .rst_req   (rst_req),
    .cnt_val   (cnt_val),
    .cur_armed (cur_armed),
    .cur_win   (cur_win),
    .tick      (tick)
);

// File: tb/test_win_wdog.sv
module test_win_wdog;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       blk_en = 1'b0;
    logic       ctl_wr = 1'b0;
    logic [7:0] ctl_data = '0;
    logic       cfg_wr = 1'b0;
    logic [6:0] cfg_win = '0;
    logic [1:0] cfg_tb = '0;
    logic       rst_req;
    logic [6:0] cnt_val;

    always #2 clk = ~clk;

    win_wdog #(.FIX_DIV(4)) i_win_wdog (
        .clk      (clk),
        .rst_n    (rst_n),
        .blk_en   (blk_en),
        .ctl_wr   (ctl_wr),
        .ctl_data (ctl_data),
        .cfg_wr   (cfg_wr),
        .cfg_win  (cfg_win),
        .cfg_tb   (cfg_tb),
        .rst_req  (rst_req),
        .cnt_val  (cnt_val)
    );

    typedef struct {
        int         c;
        logic [6:0] cnt;
        int         pulses;
        string      tag;
    } exp_t;

    exp_t q[$];
    int   cyc = 0;
    bit   rel = 1'b0;
    int   pulses = 0;
    int   checks = 0;
    int   errors = 0;
    bit   done = 1'b0;

    always @(posedge clk) if (rel) cyc <= cyc + 1;

    task automatic expect_at(input int c, input logic [6:0] cnt, input int p, input string tag);
        exp_t e;
        e.c = c; e.cnt = cnt; e.pulses = p; e.tag = tag;
        q.push_back(e);
    endtask

    // monitor: pops due items half a clock after the edge
    always @(negedge clk) begin
        if (rel) begin
            if (rst_req) pulses++;
            while (q.size() > 0 && q[0].c == cyc) begin
                exp_t e;
                e = q.pop_front();
                checks++;
                if (cnt_val !== e.cnt || pulses != e.pulses) begin
                    errors++;
                    $display("FAIL %s cyc %0d: cnt %h pulses %0d, expected cnt %h pulses %0d",
                             e.tag, cyc, cnt_val, pulses, e.cnt, e.pulses);
                end
            end
        end
    end

    task automatic wait_cyc(input int c);
        while (cyc < c) @(negedge clk);
    endtask

    task automatic wr_ctl(input int c, input logic arm, input logic [6:0] v);
        wait_cyc(c);
        ctl_wr = 1'b1; ctl_data = {arm, v};
        @(negedge clk);
        ctl_wr = 1'b0;
    endtask

    task automatic wr_cfg(input int c, input logic [6:0] w, input logic [1:0] t);
        wait_cyc(c);
        cfg_wr = 1'b1; cfg_win = w; cfg_tb = t;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic set_en(input int c, input logic v);
        wait_cyc(c);
        blk_en = v;
    endtask

    initial begin
        expect_at(1,   7'h7F, 0, "R1");
        expect_at(5,   7'h7F, 0, "R2");
        expect_at(8,   7'h7F, 0, "R2");
        expect_at(11,  7'h7F, 0, "R3");
        expect_at(12,  7'h7E, 0, "R3");
        expect_at(16,  7'h7D, 0, "R3");
        expect_at(268, 7'h3E, 0, "R4");
        expect_at(274, 7'h7F, 0, "R4");
        expect_at(276, 7'h7E, 0, "R3");
        expect_at(278, 7'h7F, 1, "R6");
        expect_at(279, 7'h7F, 1, "R9");
        expect_at(281, 7'h7F, 1, "R9");
        expect_at(282, 7'h7E, 1, "R9");
        expect_at(297, 7'h7E, 1, "R3");
        expect_at(298, 7'h7D, 1, "R3");
        expect_at(313, 7'h7D, 1, "R3");
        expect_at(314, 7'h7C, 1, "R3");
        expect_at(320, 7'h41, 1, "R11");
        expect_at(322, 7'h40, 1, "R5");
        expect_at(325, 7'h40, 1, "R5");
        expect_at(326, 7'h7F, 2, "R5");
        expect_at(327, 7'h7F, 2, "R9");
        expect_at(329, 7'h52, 2, "R7");
        expect_at(334, 7'h50, 2, "R7");
        expect_at(336, 7'h70, 2, "R7");
        expect_at(338, 7'h6F, 2, "R7");
        expect_at(526, 7'h40, 2, "R10");
        expect_at(528, 7'h45, 2, "R7");
        expect_at(530, 7'h44, 2, "R3");
        expect_at(532, 7'h7F, 3, "R8");
        expect_at(540, 7'h7F, 3, "R2");
        expect_at(543, 7'h7F, 3, "R2");
        expect_at(544, 7'h7E, 3, "R2");

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        rel   = 1'b1;
        wr_ctl(3, 1'b1, 7'h45);          // R2: ignored while disabled
        set_en(8, 1'b1);
        wr_cfg(270, 7'h60, 2'd0);
        wr_ctl(272, 1'b1, 7'h7F);        // R4: unarmed load, arms
        wr_ctl(277, 1'b1, 7'h50);        // R6: 0x7E above 0x60
        wr_cfg(283, 7'h7F, 2'd2);        // R3: divide by 4
        wr_cfg(315, 7'h7F, 2'd0);
        wr_ctl(319, 1'b1, 7'h41);        // R11: load on a step-free edge
        wr_cfg(327, 7'h50, 2'd0);
        wr_ctl(328, 1'b1, 7'h52);
        wr_ctl(335, 1'b0, 7'h70);        // R7 upper bound, R10 no disarm
        wr_ctl(527, 1'b0, 7'h45);        // R7 lower bound
        wr_ctl(531, 1'b0, 7'h30);        // R8 and R10: still armed
        set_en(533, 1'b0);
        set_en(541, 1'b1);
        wait_cyc(546);
        done = 1'b1;
    end

    initial begin
        while (!done && cyc < 3000) @(negedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual cycle %0d, expected completion before 3000", cyc);
        end
        if (q.size() != 0) begin
            checks++;
            errors++;
            $display("FAIL scoreboard: %0d items left, expected 0", q.size());
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule